// File: doc/BRIEF.md
# Reservation-Based Atomic Access Monitor

This block fronts a small shared word memory that two requesters use. Besides plain loads and stores it offers a linked read and a conditional write. Software builds lock-free read-modify-write sequences from this pair. A linked read returns the word and records, for that requester, a reservation on the word address. A later conditional write from the same requester goes to memory and reports 1 only while that reservation still stands. Otherwise memory is left alone and the write reports 0, so software can simply run the sequence again.

Any write that lands on a reserved address removes every reservation held on it. This includes a successful conditional write, which consumes its writer's own reservation. Atomicity therefore rests on invalidating reservations, not on holding the bus. Only one request is served per cycle. When both requesters present a request together, the lower-numbered requester goes first and the other waits. The outcome is exactly that of issuing the two in that order.

Top module: `llsc_monitor`

## Requirements
- R1: After a synchronous active-low reset, no response is pending, no reservation is held and every memory word reads as zero.
- R2: Operation codes on `req_op_i` are 2'b00 load, 2'b01 store, 2'b10 linked read and 2'b11 conditional write. A load returns the addressed word. A store writes the word, and its response data is zero.
- R3: A linked read returns the addressed word and records a reservation (valid plus address) for its requester. A conditional write from that requester to the same address then writes memory and returns 1.
- R4: A conditional write from a requester that holds no valid reservation returns 0 and leaves memory unchanged.
- R5: A conditional write whose address differs from its requester's reservation returns 0, leaves memory unchanged and leaves that reservation in place.
- R6: Any store, and any successful conditional write, to an address clears the reservations of all requesters on that address, its own included.
- R7: Loads, linked reads by other requesters, and writes to other addresses do not disturb a reservation.
- R8: A new linked read replaces its requester's previous reservation.
- R9: With several requests valid, the lowest-numbered requester is accepted (`req_rdy_o` high). The others see `req_rdy_o` low and hold their request. The results equal those of serving the requests one after another in index order.
- R10: A request accepted in one cycle produces a one-cycle pulse on its bit of `rsp_vld_o` in the next cycle, and at most one such bit is set at a time. Conditional-write results are 0 or 1, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | NREQ | Request valid, one bit per requester |
| req_op_i | input | NREQ x 2 | Operation code per requester |
| req_addr_i | input | NREQ x ADDR_W | Word address per requester |
| req_wdata_i | input | NREQ x DATA_W | Write data per requester |
| req_rdy_o | output | NREQ | Request accepted this cycle |
| rsp_vld_o | output | NREQ | Response valid for that requester |
| rsp_data_o | output | DATA_W | Read data, conditional-write result, or zero |

## Verification
Two functions can fall in the same cycle: a request from requester 0 and a request from requester 1. One of them may write a word that the other reads or holds a reservation on. The directed bench raises both valids on the same clock edge with colliding addresses. One case pairs a store with a load of the same word. Another pairs a linked read with the other side's conditional write on the word it already reserved. The bench checks that requester 1 is held for one cycle, and that both responses carry the values that strict index-order serialisation predicts.

// File: rtl/llsc_pkg.sv
// Package: shared operation encoding for the reservation monitor.
// Assumes a two-bit operation field on every requester port.
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_LINK   = 2'b10,
        OP_CONDWR = 2'b11
    } op_e;

    // True for operations that may modify memory.
    function automatic logic op_writes(input op_e op);
        return (op == OP_STORE) || (op == OP_CONDWR);
    endfunction

    // True for operations that return memory contents.
    function automatic logic op_reads(input op_e op);
        return (op == OP_LOAD) || (op == OP_LINK);
    endfunction

endpackage

// File: rtl/llsc_arb.sv
// Module: fixed-priority single-grant arbiter.
// Grants at most one requester per cycle, lowest index first.
// Assumes requesters hold their request until granted.
module llsc_arb #(
    parameter int NREQ  = 2,
    localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req_vld,
    output logic [NREQ-1:0]  gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);

    // Pick the lowest-numbered valid request; nothing is granted in reset.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            if (req_vld[k] && rst_n) begin
                gnt     = '0;
                gnt[k]  = 1'b1;
                gnt_idx = IDX_W'(k);
                gnt_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/llsc_resv.sv
// Module: per-requester reservation table.
// Each requester owns one valid bit and one word address. A linked read
// overwrites the owner's entry; any write to a matching address clears
// every entry holding it. Assumes at most one granted operation per cycle.
module llsc_resv
    import llsc_pkg::*;
#(
    parameter int NREQ   = 2,
    parameter int ADDR_W = 4,
    localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_any,
    input  logic [IDX_W-1:0]  gnt_idx,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              cond_ok
);

    logic [NREQ-1:0]             rsv_vld;
    logic [NREQ-1:0][ADDR_W-1:0] rsv_addr;

    for (genvar g = 0; g < NREQ; g++) begin : g_entry
        logic is_owner;
        logic hit;

        assign is_owner = gnt_any && (gnt_idx == IDX_W'(g));
        assign hit      = rsv_vld[g] && (rsv_addr[g] == addr);

        // Record on own linked read, drop when any write hits the address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsv_vld[g]  <= 1'b0;
                rsv_addr[g] <= '0;
            end else if (is_owner && op == OP_LINK) begin
                rsv_vld[g]  <= 1'b1;
                rsv_addr[g] <= addr;
            end else if (wr_en && hit) begin
                rsv_vld[g]  <= 1'b0;
            end
        end
    end

    // Conditional write passes when the granted requester's entry matches.
    always_comb begin
        cond_ok = 1'b0;
        for (int k = 0; k < NREQ; k++) begin
            if (gnt_idx == IDX_W'(k)) begin
                cond_ok = rsv_vld[k] && (rsv_addr[k] == addr);
            end
        end
    end

endmodule

// File: rtl/llsc_mem.sv
// Module: small word memory with combinational read and clocked write.
// Cleared to zero by reset; depth is 2**ADDR_W words.
module llsc_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DEPTH-1:0][DATA_W-1:0] words;

    // Clear all words on reset, otherwise apply the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[addr] <= wdata;
        end
    end

    // Read port shows the contents before this cycle's write.
    assign rdata = words[addr];

endmodule

// File: rtl/llsc_monitor.sv
// Module: top of the reservation-based atomic access monitor.
// Arbitrates the requesters, applies one operation per cycle to the
// memory and reservation table, and registers one response per grant.
// Assumes a requester keeps its request steady until req_rdy_o is high.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NREQ   = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREQ-1:0]              req_vld_i,
    input  logic [NREQ-1:0][1:0]         req_op_i,
    input  logic [NREQ-1:0][ADDR_W-1:0]  req_addr_i,
    input  logic [NREQ-1:0][DATA_W-1:0]  req_wdata_i,
    output logic [NREQ-1:0]              req_rdy_o,
    output logic [NREQ-1:0]              rsp_vld_o,
    output logic [DATA_W-1:0]            rsp_data_o
);

    logic [NREQ-1:0]   gnt;
    logic [IDX_W-1:0]  gnt_idx;
    logic              gnt_any;
    op_e               sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              cond_ok;
    logic              wr_en;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] rsp_next;

    llsc_arb #(.NREQ(NREQ)) u_arb (
        .rst_n   (rst_n),
        .req_vld (req_vld_i),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    // Steer the granted requester's fields onto the shared datapath.
    always_comb begin
        sel_op    = OP_LOAD;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int k = 0; k < NREQ; k++) begin
            if (gnt[k]) begin
                sel_op    = op_e'(req_op_i[k]);
                sel_addr  = req_addr_i[k];
                sel_wdata = req_wdata_i[k];
            end
        end
    end

    llsc_resv #(.NREQ(NREQ), .ADDR_W(ADDR_W)) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx),
        .op      (sel_op),
        .addr    (sel_addr),
        .wr_en   (wr_en),
        .cond_ok (cond_ok)
    );

    // A store always writes; a conditional write only with its reservation.
    assign wr_en = gnt_any && op_writes(sel_op) &&
                   ((sel_op == OP_STORE) || cond_ok);

    llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (mem_rdata)
    );

    // Choose the response word for the operation being served.
    always_comb begin
        if (op_reads(sel_op)) begin
            rsp_next = mem_rdata;
        end else if (sel_op == OP_CONDWR) begin
            rsp_next = DATA_W'(cond_ok);
        end else begin
            rsp_next = '0;
        end
    end

    // Register the response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld_o  <= '0;
            rsp_data_o <= '0;
        end else begin
            rsp_vld_o  <= gnt;
            if (gnt_any) begin
                rsp_data_o <= rsp_next;
            end
        end
    end

    assign req_rdy_o = gnt;

endmodule

// File: rtl/llsc_monitor_chk.sv
// Module: protocol checker for the atomic access monitor, bound to the top.
module llsc_monitor_chk #(
    parameter int NREQ   = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NREQ-1:0]              req_vld_i,
    input logic [NREQ-1:0][1:0]         req_op_i,
    input logic [NREQ-1:0]              req_rdy_o,
    input logic [NREQ-1:0]              rsp_vld_o,
    input logic [DATA_W-1:0]            rsp_data_o
);

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_vld_o));

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rdy_o == '0) |=> (rsp_vld_o == '0));

    // R9
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i[0] |-> req_rdy_o[0]);

    for (genvar g = 0; g < NREQ; g++) begin : g_port
        // R10
        rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_rdy_o[g] |=> rsp_vld_o[g]);

        // R10
        cond_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_rdy_o[g] && req_op_i[g] == 2'b11) |=>
                (rsp_data_o[DATA_W-1:1] == '0));

        if (g > 0) begin : g_low
            // R9
            held_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_vld_i[0] && req_vld_i[g]) |-> !req_rdy_o[g]);
        end
    end

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld_i  (req_vld_i),
    .req_op_i   (req_op_i),
    .req_rdy_o  (req_rdy_o),
    .rsp_vld_o  (rsp_vld_o),
    .rsp_data_o (rsp_data_o)
);

// File: tb/llsc_monitor_tb.sv
// Directed bench for the atomic access monitor.
module llsc_monitor_tb;

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       vld = '0;
    logic [1:0][1:0]  op = '0;
    logic [1:0][3:0]  addr = '0;
    logic [1:0][31:0] wd = '0;
    logic [1:0]       rdy;
    logic [1:0]       rvld;
    logic [31:0]      rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    llsc_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld_i(vld), .req_op_i(op),
        .req_addr_i(addr), .req_wdata_i(wd), .req_rdy_o(rdy),
        .rsp_vld_o(rvld), .rsp_data_o(rdata)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One request from one side, waits for acceptance, returns response data.
    task automatic issue(input int who, input logic [1:0] o, input logic [3:0] a,
                         input logic [31:0] d, output logic [31:0] r);
        vld[who] = 1'b1; op[who] = o; addr[who] = a; wd[who] = d;
        #1;
        while (!rdy[who]) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        vld[who] = 1'b0;
        check("R10 rsp_vld", 32'(rvld), (who == 0) ? 32'd1 : 32'd2);
        r = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 rsp_vld after reset", 32'(rvld), 32'd0);
        check("R1 rdy idle", 32'(rdy), 32'd0);
        issue(0, LD, 4'd5, 0, r);  check("R1 word 5 zero", r, 32'd0);
        issue(1, LD, 4'd15, 0, r); check("R1 word 15 zero", r, 32'd0);
        issue(1, SC, 4'd15, 32'h1234, r); check("R1 no reservation", r, 32'd0);
    endtask

    task automatic t_ld_st();
        logic [31:0] r;
        issue(1, ST, 4'd3, 32'hA5A5_0001, r); check("R2 store rsp zero", r, 32'd0);
        issue(0, LD, 4'd3, 0, r); check("R2 load after store", r, 32'hA5A5_0001);
    endtask

    task automatic t_ll_sc();
        logic [31:0] r;
        issue(0, ST, 4'd4, 32'h0000_0042, r);
        issue(0, LL, 4'd4, 0, r); check("R3 linked read data", r, 32'h42);
        issue(0, SC, 4'd4, 32'h1111, r); check("R3 cond write ok", r, 32'd1);
        issue(1, LD, 4'd4, 0, r); check("R3 cond write stored", r, 32'h1111);
        issue(0, SC, 4'd4, 32'h2222, r); check("R6 own reservation consumed", r, 32'd0);
        issue(1, LD, 4'd4, 0, r); check("R4 memory unchanged", r, 32'h1111);
    endtask

    task automatic t_no_resv();
        logic [31:0] r;
        issue(1, SC, 4'd6, 32'h77, r); check("R4 no reservation fails", r, 32'd0);
        issue(0, LD, 4'd6, 0, r); check("R4 word untouched", r, 32'd0);
    endtask

    task automatic t_mismatch();
        logic [31:0] r;
        issue(1, LL, 4'd7, 0, r);
        issue(1, SC, 4'd8, 32'h88, r); check("R5 address mismatch fails", r, 32'd0);
        issue(0, LD, 4'd8, 0, r); check("R5 word untouched", r, 32'd0);
        issue(1, SC, 4'd7, 32'h99, r); check("R5 reservation kept", r, 32'd1);
        issue(0, LD, 4'd7, 0, r); check("R3 word written", r, 32'h99);
    endtask

    task automatic t_cancel();
        logic [31:0] r;
        issue(0, LL, 4'd9, 0, r);
        issue(1, ST, 4'd9, 32'hAAAA, r);
        issue(0, SC, 4'd9, 32'hBBBB, r); check("R6 store cancels", r, 32'd0);
        issue(0, LD, 4'd9, 0, r); check("R6 other store kept", r, 32'hAAAA);
    endtask

    task automatic t_other();
        logic [31:0] r;
        issue(0, LL, 4'd10, 0, r);
        issue(1, ST, 4'd11, 32'hCC, r);
        issue(1, LD, 4'd10, 0, r);
        issue(1, LL, 4'd10, 0, r);
        issue(0, SC, 4'd10, 32'hDD, r); check("R7 unrelated traffic", r, 32'd1);
        issue(1, SC, 4'd10, 32'hEE, r); check("R6 success clears others", r, 32'd0);
        issue(1, LD, 4'd10, 0, r); check("R6 first writer kept", r, 32'hDD);
    endtask

    task automatic t_replace();
        logic [31:0] r;
        issue(0, LL, 4'd13, 0, r);
        issue(0, LL, 4'd14, 0, r);
        issue(0, SC, 4'd13, 32'hF3, r); check("R8 old reservation gone", r, 32'd0);
        issue(0, SC, 4'd14, 32'hF4, r); check("R8 new reservation holds", r, 32'd1);
    endtask

    // Both sides in one cycle; side 0 must go first.
    task automatic both(input logic [1:0] o0, input logic [3:0] a0, input logic [31:0] d0,
                        input logic [1:0] o1, input logic [3:0] a1, input logic [31:0] d1,
                        output logic [31:0] r0, output logic [31:0] r1);
        vld = 2'b11; op[0] = o0; op[1] = o1; addr[0] = a0; addr[1] = a1;
        wd[0] = d0; wd[1] = d1;
        #1;
        check("R9 only side 0 accepted", 32'(rdy), 32'd1);
        @(posedge clk);
        @(negedge clk);
        check("R10 side 0 response", 32'(rvld), 32'd1);
        r0 = rdata;
        vld[0] = 1'b0;
        #1;
        check("R9 side 1 accepted next", 32'(rdy), 32'd2);
        @(posedge clk);
        @(negedge clk);
        check("R10 side 1 response", 32'(rvld), 32'd2);
        r1 = rdata;
        vld[1] = 1'b0;
    endtask

    task automatic t_simul();
        logic [31:0] r0, r1;
        both(ST, 4'd2, 32'h5151, LD, 4'd2, 0, r0, r1);
        check("R9 store rsp", r0, 32'd0);
        check("R9 load sees earlier store", r1, 32'h5151);
        issue(1, LL, 4'd1, 0, r0);
        both(LL, 4'd1, 0, SC, 4'd1, 32'h6161, r0, r1);
        check("R9 linked read data", r0, 32'd0);
        check("R7 other link keeps reservation", r1, 32'd1);
        issue(0, LD, 4'd1, 0, r0); check("R9 serial result", r0, 32'h6161);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ld_st();
        t_ll_sc();
        t_no_resv();
        t_mismatch();
        t_cancel();
        t_other();
        t_replace();
        t_simul();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

endmodule